// File: doc/BRIEF.md
# Shared-Prescaler Timer and Watchdog

This block holds an 8-bit up-counter and a watchdog timer that share a single 8-bit prescaler. A 6-bit mode register selects four things: the counter's clock source (the instruction-cycle enable or transitions on an external pin), which edge of that pin counts, which of the two timers owns the prescaler, and the division ratio. The timer that does not own the prescaler runs undivided. A processor core uses this block by writing the mode register, loading or reading the counter, and issuing the watchdog-clear or sleep strobes from its instruction decoder.

The watchdog has a base period of `WDT_BASE` clock cycles. When it expires it raises a one-cycle reset request and sets a sticky timeout flag. A 3-bit code selects the ratio, and the same code means different ratios for the two owners: for the counter, code n divides by 2^(n+1); for the watchdog, it divides by 2^n. The external pin passes through a two-flop synchroniser before the edge detector, so one detected transition gives one count.

Top module: `timer_wdog`

## Requirements
- R1: After reset, `mode_q` reads 6'h3F (external source, falling edge, prescaler owned by the watchdog, code 7), `cnt_q` is 0, and `cnt_ovf`, `wdt_rst_req` and `wdt_tof` are 0.
- R2: With mode bit 5 = 0 (internal source) and bit 3 = 0 (prescaler owned by the counter), the counter advances once per 2^(code+1) clocks in which `cyc_en` is high, where code is mode bits 2:0.
- R3: With mode bit 3 = 1, the counter advances on every source event, and the watchdog fires 2^code × `WDT_BASE` clocks after it was last cleared. With bit 3 = 0, the watchdog fires every `WDT_BASE` clocks.
- R4: With mode bit 5 = 1, the counter counts pin transitions and ignores `cyc_en`. Mode bit 4 = 0 selects rising transitions and 1 selects falling ones. A pin change first sampled at clock edge P updates `cnt_q` at edge P+2.
- R5: `cnt_we` loads `cnt_wdata` into the counter at the next edge, and a load takes priority over a count. While the counter owns the prescaler, the load also clears the prescaler.
- R6: The counter wraps from FFh to 00h, and `cnt_ovf` is high for exactly the cycle in which `cnt_q` first shows 00h.
- R7: A watchdog expiry drives `wdt_rst_req` high for one cycle and sets `wdt_tof`, which stays set until a watchdog clear or sleep strobe.
- R8: `wdt_clr` or `sleep_req` restarts the watchdog base count. While the watchdog owns the prescaler, either strobe also clears the prescaler.
- R9: With the internal source selected and `cyc_en` low, both the counter and the prescaler hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Instruction-cycle enable (internal count source) |
| ext_pin | input | 1 | Asynchronous external count input |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 6 | Mode write data: [5] source, [4] edge, [3] owner, [2:0] ratio code |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| wdt_clr | input | 1 | Watchdog clear strobe |
| sleep_req | input | 1 | Sleep strobe, also clears the watchdog |
| mode_q | output | 6 | Current mode register |
| cnt_q | output | 8 | Counter value |
| cnt_ovf | output | 1 | One-cycle pulse on counter wrap |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |
| wdt_tof | output | 1 | Sticky watchdog timeout flag |

## Verification
The properties assume that `WDT_BASE` is at least 2, so that two expiries can never fall on adjacent cycles. They also assume that a mode write and a counter write never occur together in a cycle where the counter is expected to hold. The stimulus respects both assumptions. It uses a base period of 16 and issues every strobe for a single cycle on its own. It changes the external pin only at falling clock edges and holds each level for several cycles, so every transition passes through the synchroniser cleanly.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int PSC_W  = 8;
  localparam int CODE_W = 3;
  localparam int MODE_W = 6;

  typedef struct packed {
    logic              src_ext;
    logic              edge_fall;
    logic              psc_to_wdt;
    logic [CODE_W-1:0] code;
  } mode_t;

  localparam mode_t MODE_RST = '{src_ext: 1'b1, edge_fall: 1'b1,
                                 psc_to_wdt: 1'b1, code: '1};

  // Low-bit mask for the prescaler compare: 2^n-1 for the watchdog, 2^(n+1)-1 for the counter
  function automatic logic [PSC_W-1:0] psc_mask(input logic [CODE_W-1:0] code,
                                                input logic for_wdt);
    logic [PSC_W:0] span;
    span = for_wdt ? ((PSC_W+1)'(1) << code) : ((PSC_W+1)'(2) << code);
    return PSC_W'(span - (PSC_W+1)'(1));
  endfunction
endpackage

// File: rtl/tw_sync_edge.sv
module tw_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[STAGES-1:0], pin};
  end

  assign rise =  sync_q[STAGES-1] & ~sync_q[STAGES];
  assign fall = ~sync_q[STAGES-1] &  sync_q[STAGES];
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] mask,
  output logic         tick
);
  logic [W-1:0] psc_q;

  always_ff @(posedge clk) begin
    if (rst || clr) psc_q <= '0;
    else if (inc)   psc_q <= psc_q + W'(1);
  end

  assign tick = inc && !clr && ((psc_q | ~mask) == '1);
endmodule

// File: rtl/tw_wdog_base.sv
module tw_wdog_base #(
  parameter int BASE = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic base_tick
);
  localparam int CW = (BASE > 2) ? $clog2(BASE) : 1;
  localparam logic [CW-1:0] LAST = CW'(BASE - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + CW'(1);
  end

  assign base_tick = (cnt_q == LAST) && !clr;
endmodule

// File: rtl/timer_wdog.sv
module timer_wdog #(
  parameter int WDT_BASE    = 1000,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cyc_en,
  input  logic                      ext_pin,
  input  logic                      mode_we,
  input  logic [tw_pkg::MODE_W-1:0] mode_wdata,
  input  logic                      cnt_we,
  input  logic [CNT_W-1:0]          cnt_wdata,
  input  logic                      wdt_clr,
  input  logic                      sleep_req,
  output logic [tw_pkg::MODE_W-1:0] mode_q,
  output logic [CNT_W-1:0]          cnt_q,
  output logic                      cnt_ovf,
  output logic                      wdt_rst_req,
  output logic                      wdt_tof
);
  import tw_pkg::*;

  mode_t             mode_r;
  logic              pin_rise, pin_fall, ext_evt, src_evt;
  logic              wd_clr, base_tick;
  logic              psc_clr, psc_inc, psc_tick;
  logic [PSC_W-1:0]  mask;
  logic              cnt_tick, wdt_fire;

  always_ff @(posedge clk) begin
    if (rst)          mode_r <= MODE_RST;
    else if (mode_we) mode_r <= mode_t'(mode_wdata);
  end
  assign mode_q = mode_r;

  tw_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .pin(ext_pin), .rise(pin_rise), .fall(pin_fall)
  );

  assign ext_evt = mode_r.edge_fall ? pin_fall : pin_rise;
  assign src_evt = mode_r.src_ext ? ext_evt : cyc_en;
  assign wd_clr  = wdt_clr | sleep_req;

  tw_wdog_base #(.BASE(WDT_BASE)) i_base (
    .clk(clk), .rst(rst), .clr(wd_clr), .base_tick(base_tick)
  );

  assign psc_clr = mode_r.psc_to_wdt ? wd_clr    : cnt_we;
  assign psc_inc = mode_r.psc_to_wdt ? base_tick : src_evt;
  assign mask    = psc_mask(mode_r.code, mode_r.psc_to_wdt);

  tw_prescaler #(.W(PSC_W)) i_psc (
    .clk(clk), .rst(rst), .clr(psc_clr), .inc(psc_inc), .mask(mask), .tick(psc_tick)
  );

  assign cnt_tick = mode_r.psc_to_wdt ? src_evt  : psc_tick;
  assign wdt_fire = mode_r.psc_to_wdt ? psc_tick : base_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      cnt_ovf <= 1'b0;
    end else if (cnt_we) begin
      cnt_q   <= cnt_wdata;
      cnt_ovf <= 1'b0;
    end else if (cnt_tick) begin
      {cnt_ovf, cnt_q} <= {1'b0, cnt_q} + (CNT_W+1)'(1);
    end else begin
      cnt_ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wdt_rst_req <= 1'b0;
      wdt_tof     <= 1'b0;
    end else begin
      wdt_rst_req <= wdt_fire;
      if (wd_clr)        wdt_tof <= 1'b0;
      else if (wdt_fire) wdt_tof <= 1'b1;
    end
  end
endmodule

// File: rtl/timer_wdog_chk.sv
module timer_wdog_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_en,
  input logic             mode_we,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             wdt_clr,
  input logic             sleep_req,
  input logic [5:0]       mode_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             cnt_ovf,
  input logic             wdt_rst_req,
  input logic             wdt_tof
);
  // R6: overflow pulse only with a zero count
  p_ovf_zero_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_ovf |-> (cnt_q == '0));

  // R2: without a write the counter holds or steps by one
  p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
    !cnt_we |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R5: a write lands on the next edge
  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (cnt_q == $past(cnt_wdata)));

  // R7: the reset request is a single-cycle pulse and comes with the flag
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_req |=> !wdt_rst_req);
  p_req_flag_r7: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_req |-> wdt_tof);

  // R8: a clear or sleep strobe suppresses expiry and drops the flag
  p_clr_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (wdt_clr || sleep_req) |=> (!wdt_rst_req && !wdt_tof));

  // R9: internal source with the enable low holds the count
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!cyc_en && !mode_q[5] && !cnt_we && !mode_we) |=> $stable(cnt_q));
endmodule

bind timer_wdog timer_wdog_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_timer_wdog.sv
module test_timer_wdog;
  localparam int BASE = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_en = 1'b1;
  logic       ext_pin = 1'b0;
  logic       mode_we = 1'b0;
  logic [5:0] mode_wdata = '0;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic       wdt_clr = 1'b0;
  logic       sleep_req = 1'b0;
  logic [5:0] mode_q;
  logic [7:0] cnt_q;
  logic       cnt_ovf, wdt_rst_req, wdt_tof;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  timer_wdog #(.WDT_BASE(BASE)) i_timer_wdog (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .ext_pin(ext_pin),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .wdt_clr(wdt_clr), .sleep_req(sleep_req), .mode_q(mode_q), .cnt_q(cnt_q),
    .cnt_ovf(cnt_ovf), .wdt_rst_req(wdt_rst_req), .wdt_tof(wdt_tof)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // All strobes are set at a falling edge and sampled at the next rising edge
  task automatic wr_mode(input logic [5:0] m);
    mode_we = 1'b1; mode_wdata = m; @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_we = 1'b1; cnt_wdata = v; @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic pulse_clr(input bit use_sleep);
    if (use_sleep) sleep_req = 1'b1; else wdt_clr = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0; wdt_clr = 1'b0;
  endtask

  // Request expected exactly at edge 'at' (or never if at<=0) within 'len' edges
  task automatic watch_req(input int len, input int at, input string rq);
    int bad = 0;
    int first_bad = -1;
    for (int j = 1; j <= len; j++) begin
      @(negedge clk);
      if (wdt_rst_req !== (j == at)) begin
        bad++;
        if (first_bad < 0) first_bad = j;
      end
    end
    check(bad == 0, rq, first_bad, at);
  endtask

  task automatic t_reset;
    rst = 1'b1; step(3); rst = 1'b0;
    check(mode_q == 6'h3F, "R1 mode", mode_q, 6'h3F);
    check(cnt_q == 8'h00 && !cnt_ovf, "R1 count", cnt_q, 0);
    check(!wdt_rst_req && !wdt_tof, "R1 watchdog", wdt_tof, 0);
    // default: watchdog owns prescaler at code 7 -> 128 base periods
    watch_req(128*BASE + 1, 128*BASE, "R3 default watchdog period");
    check(wdt_tof == 1'b1, "R7 flag set", wdt_tof, 1);
    check(cnt_q == 8'h00, "R4 idle pin no count", cnt_q, 0);
  endtask

  task automatic t_cnt_internal;
    int bad = 0;
    wr_mode(6'b000_000);
    wr_cnt(8'h00);
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      if (cnt_q != 8'(j >> 1)) bad++;
    end
    check(bad == 0, "R2 ratio 2", bad, 0);
    bad = 0;
    wr_mode(6'b000_011);
    wr_cnt(8'h00);
    for (int j = 1; j <= 64; j++) begin
      @(negedge clk);
      if (cnt_q != 8'(j >> 4)) bad++;
    end
    check(bad == 0, "R2 ratio 16", bad, 0);
  endtask

  task automatic t_cnt_direct;
    int bad = 0;
    wr_mode(6'b001_000);
    wr_cnt(8'h05);
    for (int j = 1; j <= 10; j++) begin
      @(negedge clk);
      if (cnt_q != 8'(5 + j)) bad++;
    end
    check(bad == 0, "R3 counter undivided", bad, 0);
  endtask

  task automatic t_wrap;
    wr_mode(6'b001_000);
    wr_cnt(8'hFD);
    step(1); check(cnt_q == 8'hFE && !cnt_ovf, "R6 FE", cnt_q, 8'hFE);
    step(1); check(cnt_q == 8'hFF && !cnt_ovf, "R6 FF", cnt_q, 8'hFF);
    step(1); check(cnt_q == 8'h00 && cnt_ovf,  "R6 wrap pulse", cnt_ovf, 1);
    step(1); check(cnt_q == 8'h01 && !cnt_ovf, "R6 pulse ends", cnt_ovf, 0);
  endtask

  task automatic t_write_clears;
    wr_mode(6'b000_001);           // counter owns prescaler, ratio 4
    wr_cnt(8'd10);
    step(2);
    check(cnt_q == 8'd10, "R5 before reload", cnt_q, 10);
    wr_cnt(8'd20);
    check(cnt_q == 8'd20, "R5 load value", cnt_q, 20);
    step(3);
    check(cnt_q == 8'd20, "R5 prescaler cleared", cnt_q, 20);
    step(1);
    check(cnt_q == 8'd21, "R5 first tick after clear", cnt_q, 21);
  endtask

  task automatic t_cyc_en;
    wr_mode(6'b001_000);
    wr_cnt(8'h40);
    cyc_en = 1'b0; step(5);
    check(cnt_q == 8'h40, "R9 counter holds", cnt_q, 8'h40);
    cyc_en = 1'b1; step(1);
    check(cnt_q == 8'h41, "R9 resumes", cnt_q, 8'h41);
    wr_mode(6'b000_000);
    wr_cnt(8'h00);
    step(1);                       // prescaler at 1
    cyc_en = 1'b0; step(5);
    check(cnt_q == 8'h00, "R9 held before tick", cnt_q, 0);
    cyc_en = 1'b1; step(1);
    check(cnt_q == 8'h01, "R9 prescaler held", cnt_q, 1);
  endtask

  task automatic t_external;
    ext_pin = 1'b0;
    wr_mode(6'b101_000);           // pin, rising, undivided
    step(4);
    wr_cnt(8'h00);
    ext_pin = 1'b1;
    step(1); check(cnt_q == 8'h00, "R4 latency edge P", cnt_q, 0);
    step(1); check(cnt_q == 8'h00, "R4 latency edge P+1", cnt_q, 0);
    step(1); check(cnt_q == 8'h01, "R4 count at edge P+2", cnt_q, 1);
    for (int k = 0; k < 5; k++) begin
      ext_pin = 1'b0; step(3);
      ext_pin = 1'b1; step(3);
    end
    step(4);
    check(cnt_q == 8'd6, "R4 rising count", cnt_q, 6);
    wr_mode(6'b111_000);           // falling edges
    wr_cnt(8'h00);
    for (int k = 0; k < 4; k++) begin
      ext_pin = 1'b0; step(3);
      ext_pin = 1'b1; step(3);
    end
    step(4);
    check(cnt_q == 8'd4, "R4 falling count", cnt_q, 4);
  endtask

  task automatic t_watchdog;
    wr_mode(6'b001_000);           // watchdog owns prescaler, ratio 1
    pulse_clr(1'b0);
    check(!wdt_tof, "R7 flag cleared", wdt_tof, 0);
    watch_req(BASE + 1, BASE, "R3 watchdog ratio 1");
    check(wdt_tof, "R7 flag sticky", wdt_tof, 1);
    wr_mode(6'b001_010);           // ratio 4
    pulse_clr(1'b0);
    watch_req(4*BASE + 1, 4*BASE, "R3 watchdog ratio 4");
    wr_mode(6'b000_010);           // counter owns prescaler: base period only
    pulse_clr(1'b0);
    watch_req(BASE + 1, BASE, "R3 watchdog without prescaler");
  endtask

  task automatic t_wdt_clear;
    wr_mode(6'b001_010);           // watchdog owns prescaler, ratio 4
    pulse_clr(1'b0);
    watch_req(3*BASE, 0, "R8 no early expiry");
    pulse_clr(1'b1);               // sleep strobe clears prescaler too
    check(!wdt_tof, "R8 sleep clears flag", wdt_tof, 0);
    watch_req(4*BASE + 1, 4*BASE, "R8 full period after sleep");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_cnt_internal();
    t_cnt_direct();
    t_wrap();
    t_write_clears();
    t_cyc_en();
    t_external();
    t_watchdog();
    t_wdt_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule